// File: doc/BRIEF.md
# Parallel Frame Alignment Monitor

This block keeps the channel count of a byte-wide TDM port. On each byte clock it advances a channel counter that wraps at a frame length chosen by a rate select. It also judges every incoming frame pulse against the boundary the counter predicts. A pulse that lands on the expected boundary is simply confirmed. A pulse that lands anywhere else moves the counter to the new alignment and raises a sticky alarm flag, which a CPU clears with a one-cycle clear strobe.

Frames with no pulse at all are allowed: the counter keeps running on its own timing and no alarm is raised. A frame input that stays at its active level for too long is taken as a stalled port. The counter is then pinned at channel 0 and the frame-start strobe is suppressed until the input is released. The active level of the pulse is set by a polarity input. The first pulse after reset sets the initial alignment without raising the alarm.

Top module: `pfa_monitor`

## Requirements
- R1: While reset is held and on the first cycle after it, `chan_cnt` is 0, `align_irq` is 0 and `frame_start` is 1.
- R2: With no pulses, `chan_cnt` counts 0 up to N-1 and then returns to 0. N is 2430 for `rate_sel` 2'b00, 2048 for 2'b01, 810 for 2'b10, and 2430 for 2'b11.
- R3: `frame_start` is 1 exactly when `chan_cnt` is 0 and the port is not stalled.
- R4: With `pulse_pol` 1 the active level of `frame_in` is high; with `pulse_pol` 0 it is low. Only the transition into the active level (a rising active edge) is judged.
- R5: A rising active edge sampled while `chan_cnt` is N-1 raises no alarm, and the counter goes to 0 on the next clock as usual.
- R6: After the first edge, a rising active edge sampled at any other count sets `align_irq` on the next clock. On that same clock `chan_cnt` becomes 0, and counting resumes from the new alignment.
- R7: The first rising active edge after reset realigns `chan_cnt` to 0 on the next clock and does not set `align_irq`.
- R8: Frames without a pulse leave `align_irq` unchanged and the counter free-running.
- R9: An active level held for fewer than HOLD_LIM (default 8) clocks counts as one event. The counter keeps advancing while the level is held.
- R10: Once the active level has been sampled on HOLD_LIM consecutive clocks, `chan_cnt` stays 0 and `frame_start` stays 0. The first clock after release gives `chan_cnt` = 1.
- R11: `align_irq` stays 1 until a clock on which `irq_clr` is 1, after which it is 0. An alarm arising on the same clock as the clear leaves it 1.
- R12: If `rate_sel` changes to a shorter frame while `chan_cnt` is at or past the new N-1, the counter returns to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock of the parallel port |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Frame length select (see R2) |
| pulse_pol | input | 1 | Active level of the frame pulse, 1 = high |
| frame_in | input | 1 | Parallel frame pulse |
| irq_clr | input | 1 | CPU clear of the alarm flag |
| chan_cnt | output | 12 | Current channel time within the frame |
| frame_start | output | 1 | High on channel 0 while not stalled |
| align_irq | output | 1 | Sticky misalignment alarm |

## Verification
The hardest state to reach from the ports is a misplaced edge that falls on the same clock as the CPU clear. To get there, the bench waits on the visible channel count. At the falling clock edge before the chosen count, it drives the pulse and the clear together, so both are sampled on one rising edge. The stall case needs a long unbroken active level. It is driven after an earlier edge has already realigned the counter, so the bench can predict the count at every step up to the point where it is pinned.

// File: rtl/pfa_pkg.sv
package pfa_pkg;

   typedef enum logic [1:0] {
      RATE_HI  = 2'b00,
      RATE_MID = 2'b01,
      RATE_LO  = 2'b10,
      RATE_ALT = 2'b11
   } rate_e;

   typedef struct packed {
      logic rise;      // transition into the active level this cycle
      logic hold_now;  // active level has lasted HOLD_LIM samples incl. this one
      logic stalled;   // registered stall state
   } pulse_ev_t;

   function automatic int unsigned pick_len(input rate_e sel,
                                            input int unsigned len_hi,
                                            input int unsigned len_mid,
                                            input int unsigned len_lo);
      case (sel)
         RATE_MID: return len_mid;
         RATE_LO:  return len_lo;
         default:  return len_hi;
      endcase
   endfunction

endpackage

// File: rtl/pfa_edge.sv
module pfa_edge
   import pfa_pkg::*;
#(
   parameter int unsigned HOLD_LIM  = 8,
   parameter int unsigned IN_STAGES = 0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      frame_in,
   input  logic      pol,
   output pulse_ev_t ev
);

   localparam int unsigned RUN_W = $clog2(HOLD_LIM + 1);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(HOLD_LIM);
   localparam logic [RUN_W-1:0] RUN_TRIP = RUN_W'(HOLD_LIM - 1);

   logic             raw;
   logic             act;
   logic             prev_q;
   logic [RUN_W-1:0] run_q;
   logic             stall_q;
   logic             hold_now;

   generate
      if (IN_STAGES == 0) begin : g_direct
         assign raw = frame_in;
      end else begin : g_sync
         logic [IN_STAGES-1:0] sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[IN_STAGES-2+((IN_STAGES==1)?1:0):0], frame_in};
         end
         assign raw = sync_q[IN_STAGES-1];
      end
   endgenerate

   assign act      = (raw == pol);
   assign hold_now = act && (run_q >= RUN_TRIP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q  <= 1'b1;
         run_q   <= '0;
         stall_q <= 1'b0;
      end else begin
         prev_q  <= act;
         stall_q <= hold_now;
         if (!act)                 run_q <= '0;
         else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
      end
   end

   assign ev.rise     = act && !prev_q;
   assign ev.hold_now = hold_now;
   assign ev.stalled  = stall_q;

endmodule

// File: rtl/pfa_counter.sv
module pfa_counter
   import pfa_pkg::*;
#(
   parameter int unsigned CNT_W   = 12,
   parameter int unsigned LEN_HI  = 2430,
   parameter int unsigned LEN_MID = 2048,
   parameter int unsigned LEN_LO  = 810
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       rate_sel,
   input  logic             realign,
   input  logic             hold,
   output logic [CNT_W-1:0] cnt,
   output logic             at_end
);

   localparam logic [CNT_W-1:0] LAST_HI  = CNT_W'(LEN_HI - 1);
   localparam logic [CNT_W-1:0] LAST_MID = CNT_W'(LEN_MID - 1);
   localparam logic [CNT_W-1:0] LAST_LO  = CNT_W'(LEN_LO - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   always_comb begin
      case (rate_e'(rate_sel))
         RATE_MID: last = LAST_MID;
         RATE_LO:  last = LAST_LO;
         default:  last = LAST_HI;
      endcase
   end

   // ">=" so that a switch to a shorter frame wraps at once
   assign at_end = (cnt_q >= last);

   always_ff @(posedge clk) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (hold || realign || at_end) cnt_q <= '0;
      else                             cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/pfa_irq.sv
module pfa_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic rise,
   input  logic misplaced,
   input  logic clr,
   output logic flag
);

   logic armed_q;
   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         flag_q  <= 1'b0;
      end else begin
         if (rise) armed_q <= 1'b1;
         if (misplaced && armed_q) flag_q <= 1'b1;
         else if (clr)             flag_q <= 1'b0;
      end
   end

   assign flag = flag_q;

endmodule

// File: rtl/pfa_monitor.sv
module pfa_monitor
   import pfa_pkg::*;
#(
   parameter int unsigned CNT_W     = 12,
   parameter int unsigned LEN_HI    = 2430,
   parameter int unsigned LEN_MID   = 2048,
   parameter int unsigned LEN_LO    = 810,
   parameter int unsigned HOLD_LIM  = 8,
   parameter int unsigned IN_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       rate_sel,
   input  logic             pulse_pol,
   input  logic             frame_in,
   input  logic             irq_clr,
   output logic [CNT_W-1:0] chan_cnt,
   output logic             frame_start,
   output logic             align_irq
);

   localparam int unsigned CNT_SPAN = 1 << CNT_W;

   generate
      if (LEN_HI < 2 || LEN_HI > CNT_SPAN) begin : g_bad_hi
         $error("LEN_HI out of range for CNT_W");
      end
      if (LEN_MID < 2 || LEN_MID > CNT_SPAN) begin : g_bad_mid
         $error("LEN_MID out of range for CNT_W");
      end
      if (LEN_LO < 2 || LEN_LO > CNT_SPAN) begin : g_bad_lo
         $error("LEN_LO out of range for CNT_W");
      end
      if (HOLD_LIM < 2) begin : g_bad_hold
         $error("HOLD_LIM must be at least 2");
      end
   endgenerate

   pulse_ev_t        ev;
   logic             at_end;
   logic             misplaced;
   logic             stall_w;
   logic [CNT_W-1:0] cnt_w;

   pfa_edge #(
      .HOLD_LIM  (HOLD_LIM),
      .IN_STAGES (IN_STAGES)
   ) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_in (frame_in),
      .pol      (pulse_pol),
      .ev       (ev)
   );

   assign misplaced = ev.rise && !at_end && !ev.stalled;
   assign stall_w   = ev.stalled;

   pfa_counter #(
      .CNT_W   (CNT_W),
      .LEN_HI  (LEN_HI),
      .LEN_MID (LEN_MID),
      .LEN_LO  (LEN_LO)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_sel (rate_sel),
      .realign  (misplaced),
      .hold     (ev.hold_now),
      .cnt      (cnt_w),
      .at_end   (at_end)
   );

   pfa_irq u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise      (ev.rise),
      .misplaced (misplaced),
      .clr       (irq_clr),
      .flag      (align_irq)
   );

   assign chan_cnt    = cnt_w;
   assign frame_start = (cnt_w == '0) && !stall_w;

endmodule

// File: rtl/pfa_monitor_chk.sv
module pfa_monitor_chk
   import pfa_pkg::*;
#(
   parameter int unsigned CNT_W   = 12,
   parameter int unsigned LEN_HI  = 2430,
   parameter int unsigned LEN_MID = 2048,
   parameter int unsigned LEN_LO  = 810
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       rate_sel,
   input logic             irq_clr,
   input logic [CNT_W-1:0] chan_cnt,
   input logic             frame_start,
   input logic             align_irq,
   input logic             stall
);

   // R2: count either restarts or steps by one
   p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (chan_cnt == '0) || (chan_cnt == CNT_W'($past(chan_cnt) + 1'b1)));

   // R2: with a steady rate the count stays inside the frame
   p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(rate_sel) |-> (32'(chan_cnt) <
         pick_len(rate_e'(rate_sel), LEN_HI, LEN_MID, LEN_LO)));

   // R3: strobe only on channel 0
   p_start_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (chan_cnt == '0));

   // R6: a new alarm coincides with the realigned count
   p_irq_realign_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(align_irq) |-> (chan_cnt == '0));

   // R11: alarm holds without a clear
   p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (align_irq && !irq_clr) |=> align_irq);

   // R10: a stalled port is pinned at frame start with no strobe
   p_stall_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (chan_cnt == '0) && !frame_start);

endmodule

bind pfa_monitor pfa_monitor_chk #(
   .CNT_W   (CNT_W),
   .LEN_HI  (LEN_HI),
   .LEN_MID (LEN_MID),
   .LEN_LO  (LEN_LO)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rate_sel    (rate_sel),
   .irq_clr     (irq_clr),
   .chan_cnt    (chan_cnt),
   .frame_start (frame_start),
   .align_irq   (align_irq),
   .stall       (stall_w)
);

// File: tb/test_pfa_monitor.sv
module test_pfa_monitor;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  rate_sel;
   logic        pulse_pol;
   logic        frame_in;
   logic        irq_clr;
   logic [11:0] chan_cnt;
   logic        frame_start;
   logic        align_irq;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   pfa_monitor i_pfa_monitor (
      .clk         (clk),
      .rst_n       (rst_n),
      .rate_sel    (rate_sel),
      .pulse_pol   (pulse_pol),
      .frame_in    (frame_in),
      .irq_clr     (irq_clr),
      .chan_cnt    (chan_cnt),
      .frame_start (frame_start),
      .align_irq   (align_irq)
   );

   typedef struct packed {
      logic [1:0]  rate;
      logic        pol;
      logic [11:0] at;
      logic [3:0]  wid;
      logic        err;
   } vec_t;

   // R4 (pol 0 rows), R5 (err 0), R6 (err 1), R9 (wid > 1), R2 (rate 3)
   localparam vec_t VECS [12] = '{
      '{2'd0, 1'b1, 12'd2429, 4'd1, 1'b0},
      '{2'd0, 1'b1, 12'd100,  4'd1, 1'b1},
      '{2'd1, 1'b1, 12'd2047, 4'd3, 1'b0},
      '{2'd1, 1'b0, 12'd2047, 4'd1, 1'b0},
      '{2'd1, 1'b0, 12'd5,    4'd2, 1'b1},
      '{2'd2, 1'b1, 12'd809,  4'd1, 1'b0},
      '{2'd2, 1'b1, 12'd0,    4'd1, 1'b1},
      '{2'd3, 1'b1, 12'd2429, 4'd1, 1'b0},
      '{2'd3, 1'b0, 12'd2047, 4'd1, 1'b1},
      '{2'd2, 1'b0, 12'd808,  4'd4, 1'b1},
      '{2'd0, 1'b0, 12'd1,    4'd7, 1'b1},
      '{2'd1, 1'b1, 12'd1024, 4'd1, 1'b1}
   };

   function automatic int len_of(input logic [1:0] r);
      case (r)
         2'd1:    return 2048;
         2'd2:    return 810;
         default: return 2430;
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_cnt(input int target);
      while (32'(chan_cnt) != target) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired, run hung");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; rate_sel = 2'd0; pulse_pol = 1'b1;
      frame_in = 1'b0; irq_clr = 1'b0;
      repeat (5) @(negedge clk);
      chk("R1 cnt in reset", 32'(chan_cnt), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 cnt", 32'(chan_cnt), 1);
      chk("R1 irq", 32'(align_irq), 0);
      chk("R3 start off at cnt 1", 32'(frame_start), 0);

      // R7: first edge realigns silently
      wait_cnt(500);
      frame_in = 1'b1;
      @(negedge clk);
      frame_in = 1'b0;
      chk("R7 irq", 32'(align_irq), 0);
      chk("R7 cnt", 32'(chan_cnt), 0);
      chk("R3 start at cnt 0", 32'(frame_start), 1);

      // vector table
      for (int i = 0; i < 12; i++) begin
         automatic vec_t v = VECS[i];
         automatic int e0;
         irq_clr = 1'b1; rate_sel = v.rate; pulse_pol = v.pol; frame_in = ~v.pol;
         @(negedge clk);
         irq_clr = 1'b0;
         chk("R11 cleared", 32'(align_irq), 0);
         wait_cnt(32'(v.at));
         frame_in = v.pol;
         @(negedge clk);
         e0 = v.err ? 0 : ((32'(v.at) + 1) % len_of(v.rate));
         chk(v.err ? "R6 irq" : "R5 irq", 32'(align_irq), 32'(v.err));
         chk(v.err ? "R6 cnt" : "R5 cnt", 32'(chan_cnt), e0);
         repeat (32'(v.wid) - 1) @(negedge clk);
         chk("R9 cnt after width", 32'(chan_cnt), e0 + 32'(v.wid) - 1);
         frame_in = ~v.pol;
      end

      // R2 / R8: free-run periods, no pulses
      pulse_pol = 1'b1; frame_in = 1'b0;
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      for (int r = 0; r < 4; r++) begin
         automatic int n = 0;
         rate_sel = 2'(r);
         @(negedge clk);
         while (!frame_start) @(negedge clk);
         do begin
            @(negedge clk);
            n++;
         end while (!frame_start);
         chk("R2 frame length", n, len_of(2'(r)));
         chk("R8 no alarm", 32'(align_irq), 0);
      end

      // R12: shorter rate wraps
      rate_sel = 2'd0;
      wait_cnt(2000);
      rate_sel = 2'd2;
      @(negedge clk);
      chk("R12 cnt", 32'(chan_cnt), 0);
      chk("R12 irq", 32'(align_irq), 0);

      // R11: error together with clear wins
      rate_sel = 2'd0;
      wait_cnt(300);
      frame_in = 1'b1; irq_clr = 1'b1;
      @(negedge clk);
      frame_in = 1'b0; irq_clr = 1'b0;
      chk("R11 set beats clear", 32'(align_irq), 1);
      chk("R6 cnt", 32'(chan_cnt), 0);
      repeat (50) @(negedge clk);
      chk("R11 sticky", 32'(align_irq), 1);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk("R11 clear", 32'(align_irq), 0);

      // R10: held pulse stalls the port
      wait_cnt(100);
      frame_in = 1'b1;
      repeat (20) @(negedge clk);
      chk("R10 cnt pinned", 32'(chan_cnt), 0);
      chk("R10 start off", 32'(frame_start), 0);
      frame_in = 1'b0;
      @(negedge clk);
      chk("R10 cnt after release", 32'(chan_cnt), 1);
      chk("R10 start after release", 32'(frame_start), 0);

      finish_run();
   end

endmodule